// File: doc/BRIEF.md
# Processor Register Bank with Per-Index Access Rules

This block holds the architectural registers of a 32-bit core: sixteen general registers, four named working registers (accumulator, stack pointer, frame base, return link), a register that always reads zero, a read-only view of the program counter, two registers reserved for kernel software, and a reserved "no register" code. Each index has its own access rule: some are read/write, some read as zero, one is read-only, some need kernel mode, and some always fault.

The block has two read ports and one write port. Each port has an enable and a 5-bit index. Reads are combinational. A write is stored on the rising clock edge. The core supplies the current privilege level and the current program counter value. A single `fault` output rises whenever an enabled access breaks its register's rule. A blocked access changes no state and returns zero data.

Top module: `regbank_core`

## Requirements
- R1: Indices 0 to 15 are general registers. In either privilege mode they can be written, and they can be read back from either read port in the cycle after the write edge.
- R2: Indices 16 (accumulator), 17 (stack pointer), 18 (frame base) and 19 (return link) are plain 32-bit read/write registers in either mode.
- R3: Index 20 always reads as 0. A write to it is discarded without raising `fault`.
- R4: Index 21 reads the current `pc_value` input. An enabled write to it raises `fault` and changes no register.
- R5: Indices 22 and 23 can be read and written while `kernel_mode` is 1.
- R6: While `kernel_mode` is 0, an enabled read or write of index 22 or 23 raises `fault`. Such a read returns 0, and such a write leaves the register unchanged.
- R7: An enabled read or write of any index from 24 to 31 raises `fault`, and such a read returns 0.
- R8: A write becomes visible only after the rising edge. A read of the index being written in the same cycle returns the old value.
- R9: When `rst_n` is 0, every stored register is cleared to 0.
- R10: `fault` is combinational and is the OR of the violations on the three ports. It stays 0 when no port is enabled, whatever the indices are.
- R11: The two read ports are independent. Each one returns the data and applies the rules of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | 1 when the core runs privileged code |
| pc_value | input | 32 | Current program counter, shown at index 21 |
| rd_a_en | input | 1 | Read port A enable |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_en | input | 1 | Read port B enable |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_data | input | 32 | Write data |
| fault | output | 1 | Illegal access on any enabled port |

## Verification
The bench covers all 32 index codes in both privilege modes, for writes and for reads on both ports. It keeps a bench-side model of which codes may store data.

A design that let a user-mode write reach a privileged register would show that value at the next kernel read. A design that stored writes to the program counter view would return the written data instead of `pc_value`. A design that mis-decoded a code from 24 to 31 as a real register would leak stored data or miss the fault.

Each write also reads the same index in the same cycle, so a design that forwarded write data would be caught. A reset in the middle of the run, followed by a full sweep, catches any register left out of the clear.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

  // Access class of one register index
  typedef enum logic [2:0] {
    RC_OPEN,    // plain read/write storage
    RC_ZERO,    // reads zero, writes dropped
    RC_PCVIEW,  // read-only program counter view
    RC_PRIV,    // storage reachable only in kernel mode
    RC_VOID     // placeholder and unused codes: always fault
  } reg_class_e;

  // Layout: ngpr general registers, four working registers, then
  // zero, pc view, two privileged registers, placeholder.
  function automatic reg_class_e classify(input int idx, input int ngpr);
    if (idx < ngpr + 4)                          return RC_OPEN;
    else if (idx == ngpr + 4)                    return RC_ZERO;
    else if (idx == ngpr + 5)                    return RC_PCVIEW;
    else if (idx == ngpr + 6 || idx == ngpr + 7) return RC_PRIV;
    else                                         return RC_VOID;
  endfunction

  function automatic logic has_storage(input reg_class_e c);
    return (c == RC_OPEN) || (c == RC_PRIV);
  endfunction

endpackage

// File: rtl/regbank_port_check.sv
`timescale 1ns/1ps
module regbank_port_check
  import regbank_pkg::*;
#(
  parameter int NGPR     = 16,
  parameter int IDX_W    = 5,
  parameter bit IS_WRITE = 1'b0
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic             kernel,
  output reg_class_e       cls,
  output logic             illegal
);

  always_comb begin
    cls     = classify(int'(idx), NGPR);
    illegal = 1'b0;
    unique case (cls)
      RC_VOID:   illegal = en;
      RC_PRIV:   illegal = en & ~kernel;
      RC_PCVIEW: illegal = en & IS_WRITE;
      default:   illegal = 1'b0;
    endcase
  end

endmodule

// File: rtl/regbank_store.sv
`timescale 1ns/1ps
module regbank_store
  import regbank_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NGPR  = 16,
  parameter int IDX_W = 5,
  localparam int NSLOT = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_attempt,
  input  logic                        wr_commit,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [XLEN-1:0]             wr_data,
  output logic [NSLOT-1:0][XLEN-1:0]  slots
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam reg_class_e SLOT_CLS = classify(g, NGPR);
    if (has_storage(SLOT_CLS)) begin : g_held
      logic            ld;
      logic [XLEN-1:0] q, q_nxt;

      always_comb begin
        ld    = wr_commit && (wr_idx == IDX_W'(g));
        q_nxt = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= q_nxt;
      end

      assign slots[g] = q;
    end else begin : g_tied
      assign slots[g] = '0;
    end
  end

  // A refused write leaves every register untouched
  p_refused_write_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_attempt && !wr_commit |=> $stable(slots));

  // An accepted general-register write is visible after the edge
  p_gpr_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit && (int'(wr_idx) < NGPR) |=> slots[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/regbank_read_mux.sv
`timescale 1ns/1ps
module regbank_read_mux
  import regbank_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5,
  localparam int NSLOT = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]           idx,
  input  reg_class_e                 cls,
  input  logic                       illegal,
  input  logic [NSLOT-1:0][XLEN-1:0] slots,
  input  logic [XLEN-1:0]            pc_value,
  output logic [XLEN-1:0]            data
);

  always_comb begin
    data = '0;
    if (!illegal) begin
      unique case (cls)
        RC_OPEN, RC_PRIV: data = slots[idx];
        RC_PCVIEW:        data = pc_value;
        default:          data = '0;
      endcase
    end
  end

endmodule

// File: rtl/regbank_core.sv
`timescale 1ns/1ps
module regbank_core
  import regbank_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NGPR = 16,
  localparam int IDX_W = $clog2(NGPR + 9),
  localparam int NSLOT = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kernel_mode,
  input  logic [XLEN-1:0]  pc_value,
  input  logic             rd_a_en,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic             rd_b_en,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic             fault
);

  localparam logic [IDX_W-1:0] ZERO_IDX  = IDX_W'(NGPR + 4);
  localparam logic [IDX_W-1:0] PC_IDX    = IDX_W'(NGPR + 5);
  localparam logic [IDX_W-1:0] PRIV0_IDX = IDX_W'(NGPR + 6);
  localparam logic [IDX_W-1:0] PRIV1_IDX = IDX_W'(NGPR + 7);
  localparam logic [IDX_W-1:0] VOID_IDX  = IDX_W'(NGPR + 8);

  reg_class_e cls_a, cls_b, cls_w;
  logic       bad_a, bad_b, bad_w;
  logic       wr_commit;
  logic [NSLOT-1:0][XLEN-1:0] slots;

  regbank_port_check #(.NGPR(NGPR), .IDX_W(IDX_W), .IS_WRITE(1'b0)) u_chk_a (
    .en(rd_a_en), .idx(rd_a_idx), .kernel(kernel_mode), .cls(cls_a), .illegal(bad_a));

  regbank_port_check #(.NGPR(NGPR), .IDX_W(IDX_W), .IS_WRITE(1'b0)) u_chk_b (
    .en(rd_b_en), .idx(rd_b_idx), .kernel(kernel_mode), .cls(cls_b), .illegal(bad_b));

  regbank_port_check #(.NGPR(NGPR), .IDX_W(IDX_W), .IS_WRITE(1'b1)) u_chk_w (
    .en(wr_en), .idx(wr_idx), .kernel(kernel_mode), .cls(cls_w), .illegal(bad_w));

  always_comb begin
    wr_commit = wr_en && !bad_w && has_storage(cls_w);
    fault     = bad_a | bad_b | bad_w;
  end

  regbank_store #(.XLEN(XLEN), .NGPR(NGPR), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_attempt(wr_en), .wr_commit(wr_commit),
    .wr_idx(wr_idx), .wr_data(wr_data), .slots(slots));

  regbank_read_mux #(.XLEN(XLEN), .IDX_W(IDX_W)) u_mux_a (
    .idx(rd_a_idx), .cls(cls_a), .illegal(bad_a), .slots(slots),
    .pc_value(pc_value), .data(rd_a_data));

  regbank_read_mux #(.XLEN(XLEN), .IDX_W(IDX_W)) u_mux_b (
    .idx(rd_b_idx), .cls(cls_b), .illegal(bad_b), .slots(slots),
    .pc_value(pc_value), .data(rd_b_data));

  // Port-level access rules
  p_zero_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_en && (rd_a_idx == ZERO_IDX) |-> (rd_a_data == '0));

  p_pc_write_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_idx == PC_IDX) |-> fault);

  p_pc_view_reads_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_en && (rd_b_idx == PC_IDX) |-> (rd_b_data == pc_value));

  p_user_priv_write_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !kernel_mode && wr_en && ((wr_idx == PRIV0_IDX) || (wr_idx == PRIV1_IDX)) |-> fault);

  p_void_access_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && (rd_a_idx >= VOID_IDX)) || (wr_en && (wr_idx >= VOID_IDX)) |-> fault);

  p_void_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_en && (rd_b_idx >= VOID_IDX) |-> (rd_b_data == '0));

  p_idle_never_faults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_en && !rd_b_en && !wr_en |-> !fault);

endmodule

// File: tb/test_regbank_core.sv
`timescale 1ns/1ps
module test_regbank_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        kernel_mode;
  logic [31:0] pc_value;
  logic        rd_a_en, rd_b_en, wr_en;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        fault;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  regbank_core i_regbank_core (
    .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .pc_value(pc_value),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .fault(fault));

  // Bench-side rules, taken from the requirements
  function automatic bit is_stored(int i);
    return (i < 20) || (i == 22) || (i == 23);
  endfunction

  function automatic bit is_illegal(int i, bit wr, bit k);
    if (i >= 24) return 1'b1;
    if (i == 22 || i == 23) return !k;
    if (i == 21) return wr;
    return 1'b0;
  endfunction

  function automatic logic [31:0] read_exp(int i, bit k, logic [31:0] pcv);
    if (is_illegal(i, 1'b0, k)) return 32'h0;
    if (i == 20) return 32'h0;
    if (i == 21) return pcv;
    return model[i];
  endfunction

  function automatic string tag_of(int i, bit k);
    if (i < 16)  return "R1";
    if (i < 20)  return "R2";
    if (i == 20) return "R3";
    if (i == 21) return "R4";
    if (i < 24)  return k ? "R5" : "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_read(int i, bit k);
    int j = 31 - i;
    logic [31:0] pcv = 32'h4000_0000 + 32'(i * 4);
    @(negedge clk);
    wr_en = 1'b0; kernel_mode = k; pc_value = pcv;
    rd_a_en = 1'b1; rd_a_idx = 5'(i);
    rd_b_en = 1'b1; rd_b_idx = 5'(j);
    #1;
    chk(tag_of(i, k), "port A data", rd_a_data, read_exp(i, k, pcv));
    chk("R11", "port B data", rd_b_data, read_exp(j, k, pcv));
    chk(tag_of(i, k), "read fault", 32'(fault),
        32'(is_illegal(i, 1'b0, k) | is_illegal(j, 1'b0, k)));
  endtask

  task automatic do_write(int i, bit k, logic [31:0] d);
    logic [31:0] old_v;
    @(negedge clk);
    kernel_mode = k; pc_value = 32'h0000_8000;
    wr_en = 1'b1; wr_idx = 5'(i); wr_data = d;
    rd_a_en = 1'b1; rd_a_idx = 5'(i); rd_b_en = 1'b0;
    #1;
    old_v = read_exp(i, k, 32'h0000_8000);
    chk("R8", "same-cycle read", rd_a_data, old_v);
    chk(tag_of(i, k), "write fault", 32'(fault),
        32'(is_illegal(i, 1'b1, k) | is_illegal(i, 1'b0, k)));
    @(posedge clk);
    if (!is_illegal(i, 1'b1, k) && is_stored(i)) model[i] = d;
  endtask

  function automatic logic [31:0] pattern(int i, int pass);
    return {8'(i), 8'(pass), 16'hC3A5 ^ 16'(i * 97)};
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    rst_n = 1'b0; kernel_mode = 1'b0; pc_value = 32'h0;
    rd_a_en = 1'b0; rd_b_en = 1'b0; wr_en = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: idle ports never fault, even pointing at faulting codes
    @(negedge clk);
    rd_a_idx = 5'd31; rd_b_idx = 5'd24; wr_idx = 5'd21; kernel_mode = 1'b0;
    #1 chk("R10", "idle fault", 32'(fault), 32'h0);

    // R9: reset state in kernel mode
    for (int i = 0; i < 32; i++) do_read(i, 1'b1);

    // Kernel pass: write every code, then read all back
    for (int i = 0; i < 32; i++) do_write(i, 1'b1, pattern(i, 1));
    for (int i = 0; i < 32; i++) do_read(i, 1'b1);

    // User pass: privileged and pc-view writes must be refused
    for (int i = 0; i < 32; i++) do_write(i, 1'b0, pattern(i, 2));
    for (int i = 0; i < 32; i++) do_read(i, 1'b0);
    for (int i = 0; i < 32; i++) do_read(i, 1'b1);

    // R9: reset in the middle of the run clears everything
    @(negedge clk);
    rst_n = 1'b0; rd_a_en = 1'b0; rd_b_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    for (int i = 0; i < 32; i++) begin
      do_read(i, 1'b1);
      chk("R9", "post-reset port A", rd_a_data, read_exp(i, 1'b1, pc_value));
    end

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule